// File: doc/BRIEF.md
# Dual-Clock Pulse Error Detector

This block watches two count lines that should carry the same clock in opposite polarity. A rising edge on line A should be paired with a falling edge on line B, and each falling edge on B with a rising edge on A. The partner edge must arrive within a tolerance window. The window is set on the `win_len` input and measured in system-clock cycles. Any edge whose partner does not arrive in time counts as one error. The errors go into a saturating counter. A sticky flag goes high when the third error is counted.

Both lines are asynchronous. Each passes through a two-flop synchronizer and then an edge detector. A small state machine tracks the single open match. It has three states: `ST_IDLE` (nothing open), `ST_WAIT_B` (an A rise is waiting for a B fall) and `ST_WAIT_A` (a B fall is waiting for an A rise). Its transitions are:

- open: from idle, a lone A rise moves to `ST_WAIT_B` and a lone B fall moves to `ST_WAIT_A`.
- match: the partner edge arrives and the machine returns to idle.
- rearm: a second edge of the pending kind arrives. The earlier edge counts as an error and the window restarts.
- expire: the window runs out. One error is counted and the machine returns to idle.
- disable: `en` is low, which forces idle.

When both edges arrive in the same cycle from idle, they match at once.

Top module: `pulse_err_det`

## Requirements
- R1: A rise on A and a fall on B match, with no error counted, when the second of the two arrives 0 to W cycles after the first, in either order. W is `win_len`.
- R2: A rise on A with no fall on B within W cycles counts exactly one error.
- R3: A fall on B with no rise on A within W cycles counts exactly one error. If a partner arrives W+1 cycles late, both edges are unmatched and two errors are counted.
- R4: `err_flag` stays 0 while fewer than three errors have been counted. It becomes 1 once the third error is counted.
- R5: Once high, `err_flag` stays high until reset. Further errors have no effect because the count saturates at three.
- R6: While `en` is 0, edges on A and B are ignored, no error is counted and any open match is dropped.
- R7: Reset (`rst` high, synchronous) clears the count and drives `err_flag` to 0.
- R8: A `win_len` of 0 behaves as a window of 1 cycle.
- R9: A second A rise while an earlier one is still unmatched counts one error for the earlier rise and opens a fresh window for the new one. B falls behave the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Detection enable |
| line_a | input | 1 | Count line A, asynchronous, idles low |
| line_b | input | 1 | Inverted count line B, asynchronous, idles high |
| win_len | input | WIN_W | Match window in system-clock cycles |
| err_flag | output | 1 | High once three errors have been counted |

## Verification
The assertions assume the following about the inputs:

- `win_len` changes only while reset is held.
- Line A idles low and line B idles high out of reset.
- Each line holds every level for at least one system clock.

The stimulus respects all three. It drives every input at the falling clock edge and changes the window only inside a reset. It leaves each scenario with A low and B high, and it waits longer than the window plus the synchronizer delay before the next scenario.

// File: rtl/ped_pkg.sv
package ped_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT_B = 2'd1,
        ST_WAIT_A = 2'd2
    } ped_state_e;
endpackage

// File: rtl/ped_sync.sv
module ped_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= {STAGES{IDLE_VAL}};
        end else begin
            sh_q <= {sh_q[STAGES-2:0], din};
        end
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ped_edge.sv
module ped_edge #(
    parameter bit   RISING   = 1'b1,
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= IDLE_VAL;
        end else begin
            prev_q <= din;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = din & ~prev_q;
        end else begin : g_fall
            assign pulse = ~din & prev_q;
        end
    endgenerate
endmodule

// File: rtl/ped_core.sv
module ped_core
    import ped_pkg::*;
#(
    parameter int WIN_W     = 8,
    parameter int ERR_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             a_rise,
    input  logic             b_fall,
    input  logic [WIN_W-1:0] win_eff,
    output logic             miss,
    output logic             err_flag
);
    localparam int               CNT_W   = $clog2(ERR_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ERR_LIMIT);
    localparam logic [WIN_W-1:0] T_ONE   = WIN_W'(1);

    ped_state_e       state_q, state_d;
    logic [WIN_W-1:0] timer_q, timer_d;
    logic [CNT_W-1:0] cnt_q;
    logic             timed_out;

    assign timed_out = (timer_q == win_eff);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        if (!en) begin
            state_d = ST_IDLE;
            timer_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (a_rise && !b_fall) begin
                        state_d = ST_WAIT_B;
                        timer_d = T_ONE;
                    end else if (b_fall && !a_rise) begin
                        state_d = ST_WAIT_A;
                        timer_d = T_ONE;
                    end
                end
                ST_WAIT_B: begin
                    if (b_fall) begin
                        if (a_rise) begin
                            timer_d = T_ONE;
                        end else begin
                            state_d = ST_IDLE;
                            timer_d = '0;
                        end
                    end else if (a_rise) begin
                        timer_d = T_ONE;
                    end else if (timed_out) begin
                        state_d = ST_IDLE;
                        timer_d = '0;
                    end else begin
                        timer_d = timer_q + T_ONE;
                    end
                end
                ST_WAIT_A: begin
                    if (a_rise) begin
                        if (b_fall) begin
                            timer_d = T_ONE;
                        end else begin
                            state_d = ST_IDLE;
                            timer_d = '0;
                        end
                    end else if (b_fall) begin
                        timer_d = T_ONE;
                    end else if (timed_out) begin
                        state_d = ST_IDLE;
                        timer_d = '0;
                    end else begin
                        timer_d = timer_q + T_ONE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    timer_d = '0;
                end
            endcase
        end
    end

    // outputs: an error is an open match lost to rearm or expiry
    always_comb begin
        miss = 1'b0;
        if (en) begin
            unique case (state_q)
                ST_WAIT_B: miss = !b_fall && (a_rise || timed_out);
                ST_WAIT_A: miss = !a_rise && (b_fall || timed_out);
                default:   miss = 1'b0;
            endcase
        end
    end

    // saturating error count
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (miss && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign err_flag = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pulse_err_det.sv
module pulse_err_det #(
    parameter int WIN_W     = 8,
    parameter int ERR_LIMIT = 3,
    parameter int SYNC_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line_a,
    input  logic             line_b,
    input  logic [WIN_W-1:0] win_len,
    output logic             err_flag
);
    logic             a_s, b_s;
    logic             a_rise, b_fall;
    logic             miss;
    logic [WIN_W-1:0] win_eff;

    assign win_eff = (win_len == '0) ? WIN_W'(1) : win_len;

    ped_sync #(.STAGES(SYNC_LEN), .IDLE_VAL(1'b0)) u_sync_a (
        .clk(clk), .rst(rst), .din(line_a), .dout(a_s)
    );
    ped_sync #(.STAGES(SYNC_LEN), .IDLE_VAL(1'b1)) u_sync_b (
        .clk(clk), .rst(rst), .din(line_b), .dout(b_s)
    );

    ped_edge #(.RISING(1'b1), .IDLE_VAL(1'b0)) u_edge_a (
        .clk(clk), .rst(rst), .din(a_s), .pulse(a_rise)
    );
    ped_edge #(.RISING(1'b0), .IDLE_VAL(1'b1)) u_edge_b (
        .clk(clk), .rst(rst), .din(b_s), .pulse(b_fall)
    );

    ped_core #(.WIN_W(WIN_W), .ERR_LIMIT(ERR_LIMIT)) u_core (
        .clk(clk), .rst(rst), .en(en),
        .a_rise(a_rise), .b_fall(b_fall), .win_eff(win_eff),
        .miss(miss), .err_flag(err_flag)
    );
endmodule

// File: rtl/ped_core_chk.sv
module ped_core_chk
    import ped_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             a_rise,
    input logic             b_fall,
    input logic [WIN_W-1:0] win_eff,
    input ped_state_e       state_q,
    input logic [WIN_W-1:0] timer_q,
    input logic             miss,
    input logic             err_flag
);
    p_match_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_B && b_fall) |-> !miss);

    p_expire_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (en && state_q == ST_WAIT_B && !a_rise && !b_fall && timer_q == win_eff)
        |=> state_q == ST_IDLE);

    p_timer_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> (timer_q >= 1 && timer_q <= win_eff));

    p_flag_after_miss_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(miss));

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !en |-> !miss);

    p_off_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> state_q == ST_IDLE);

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !err_flag);
endmodule

bind ped_core ped_core_chk #(.WIN_W(WIN_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .a_rise(a_rise), .b_fall(b_fall),
    .win_eff(win_eff), .state_q(state_q), .timer_q(timer_q),
    .miss(miss), .err_flag(err_flag)
);

// File: tb/pulse_err_det_tb.sv
`timescale 1ns/1ps
module pulse_err_det_tb;
    localparam int WIN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b1;
    logic             line_a = 1'b0;
    logic             line_b = 1'b1;
    logic [WIN_W-1:0] win_len = 8'd6;
    logic             err_flag;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int w_cur = 6;
    int expc = 0;

    always #4 clk = ~clk;

    pulse_err_det #(.WIN_W(WIN_W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .line_a(line_a), .line_b(line_b),
        .win_len(win_len), .err_flag(err_flag)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: err_flag actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic int weff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    // kinds: 0 A then B at d, 1 B then A at d, 2 A only, 3 B only, 4 A twice then B
    function automatic int exp_errs(input int kind, input int d, input int w);
        if (kind <= 1) return (d <= weff(w)) ? 0 : 2;
        return 1;
    endfunction

    task automatic do_reset(input int w);
        @(negedge clk);
        rst = 1'b1;
        win_len = WIN_W'(w);
        w_cur = w;
        line_a = 1'b0;
        line_b = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expc = 0;
    endtask

    task automatic scn(input int kind, input int d);
        int ta = 0;
        int tb = 0;
        int span = d + 8;
        if (kind == 0) tb = d;
        if (kind == 1) ta = d;
        if (kind == 4) tb = 5;
        for (int c = 0; c < span; c++) begin
            @(negedge clk);
            line_a = (kind != 3) && ((c >= ta && c < ta + 2) ||
                                    (kind == 4 && c >= 4 && c < 6));
            line_b = !((kind != 2) && (c >= tb && c < tb + 2));
        end
        @(negedge clk);
        line_a = 1'b0;
        line_b = 1'b1;
        repeat (weff(w_cur) + 8) @(negedge clk);
    endtask

    task automatic prime(input int k);
        for (int i = 0; i < k; i++) scn(2, 0);
    endtask

    // checks the exact error count e (0..2) of one scenario through the threshold
    task automatic chk_exact(input int w, input int kind, input int d, input int e,
                             input string tag);
        do_reset(w);
        prime(2 - e);
        scn(kind, d);
        chk(err_flag, 1'b0, tag);
        if (e > 0) begin
            do_reset(w);
            prime(3 - e);
            scn(kind, d);
            chk(err_flag, 1'b1, tag);
        end
    endtask

    initial begin
        void'($urandom(32'd5151));
        do_reset(6);
        chk(err_flag, 1'b0, "R7 reset state");

        // R1 good pairs at window edges, both orders
        chk_exact(6, 0, 0, 0, "R1 same cycle");
        chk_exact(6, 0, 6, 0, "R1 A first at W");
        chk_exact(6, 1, 6, 0, "R1 B first at W");
        chk_exact(6, 1, 3, 0, "R1 B first mid");
        // R2 / R3 missing partners and late partners
        chk_exact(6, 2, 0, 1, "R2 missing B");
        chk_exact(6, 3, 0, 1, "R3 missing A");
        chk_exact(6, 0, 7, 2, "R3 late B at W+1");
        chk_exact(6, 1, 7, 2, "R3 late A at W+1");
        // R8 zero window acts as one
        chk_exact(0, 0, 1, 0, "R8 win0 offset1");
        chk_exact(0, 0, 2, 2, "R8 win0 offset2");
        // R9 rearm on second A rise
        chk_exact(6, 4, 0, 1, "R9 rearm");

        // R4 / R5 four errors in a row
        do_reset(5);
        scn(2, 0); chk(err_flag, 1'b0, "R4 after one");
        scn(3, 0); chk(err_flag, 1'b0, "R4 after two");
        scn(2, 0); chk(err_flag, 1'b1, "R4 after three");
        scn(3, 0); chk(err_flag, 1'b1, "R5 after four");
        scn(0, 1); chk(err_flag, 1'b1, "R5 sticky on good pair");
        @(negedge clk) rst = 1'b1;
        @(negedge clk) chk(err_flag, 1'b0, "R7 reset clears");
        rst = 1'b0;

        // R6 disabled detection
        do_reset(6);
        prime(2);
        en = 1'b0;
        scn(2, 0); scn(3, 0); scn(0, 9);
        chk(err_flag, 1'b0, "R6 edges ignored");
        en = 1'b1;
        scn(0, 2);
        chk(err_flag, 1'b0, "R6 after reenable");
        // R6 open match dropped by disable
        @(negedge clk) line_a = 1'b1;
        repeat (4) @(negedge clk);
        en = 1'b0;
        line_a = 1'b0;
        repeat (20) @(negedge clk);
        en = 1'b1;
        repeat (10) @(negedge clk);
        chk(err_flag, 1'b0, "R6 pending dropped");

        // random scenarios against the event-level model
        do_reset(1 + int'($urandom_range(7)));
        for (int i = 0; i < 300; i++) begin
            int kind = int'($urandom_range(4));
            int d = int'($urandom_range(weff(w_cur) + 3));
            if (kind >= 2) d = 0;
            scn(kind, d);
            expc += exp_errs(kind, d, w_cur);
            chk(err_flag, (expc >= 3), "R4 random count");
            if (expc >= 4) do_reset(int'($urandom_range(8)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule